// File: doc/BRIEF.md
# Event Identifier Counter and Queue

This block numbers the level-1 triggers seen by a timing system. It keeps a 24-bit event number and an 8-bit epoch number. The epoch counts how many times the event number has been restarted by an event-counter-reset pulse. Every accepted trigger advances the event number and pushes the combined 32-bit identifier, epoch and event number, into a small queue. Software later drains the queue one 16-bit halfword at a time.

The event number restarts at all ones. The first trigger after a restart therefore carries event number zero. A queue entry is read as two halfwords. The low halfword holds event bits 15:0. The high halfword holds the epoch in bits 15:8 and event bits 23:16 in bits 7:0. Reading the high halfword after the low one retires the entry.

A two-state read sequencer, `RD_WAIT_LO` and `RD_WAIT_HI`, enforces this order:
- `RD_WAIT_LO` goes to `RD_WAIT_HI` on a low read of a non-empty queue (transition *lo_taken*).
- `RD_WAIT_HI` goes back to `RD_WAIT_LO` on a high read (transition *hi_popped*).
- A queue clear forces `RD_WAIT_LO` from either state (transition *flush*).
- Any other stimulus holds the state (transition *hold*).

The current identifier and a four-bit indicator of the event number are always visible. A status word reports the queue fill and two sticky error flags.

Top module: `evq_top`

## Requirements
- R1: After reset the identifier output is 0x00FFFFFF (epoch 0, event 0xFFFFFF), the status word is 0x0001, the read data is 0x0000 and the indicator is 0xF.
- R2: A trigger cycle with no event reset and no event clear in the same cycle increments the event number modulo 2^24. It also pushes {epoch, new event number} into the queue. Both results are visible after that clock edge.
- R3: An event-counter-reset pulse sets the event number to 0xFFFFFF and increments the epoch modulo 256. A trigger in the same cycle is neither counted nor queued.
- R4: The event-clear command sets the event number to 0xFFFFFF and leaves the epoch unchanged. The epoch-clear command sets the epoch to 0 and wins over a simultaneous epoch increment.
- R5: The indicator output always equals event bits 3:0.
- R6: A low read of a non-empty queue returns event bits 15:0 of the oldest entry and does not remove it. It moves the sequencer to `RD_WAIT_HI`.
- R7: A high read returns {epoch, event bits 23:16} of the oldest entry. In `RD_WAIT_HI` it removes the entry and returns to `RD_WAIT_LO`. In `RD_WAIT_LO` it removes nothing.
- R8: Any read of an empty queue returns 0x0000 and sets the sticky underflow flag.
- R9: A push into a full queue is dropped. It sets the sticky overflow flag and leaves the stored entries intact.
- R10: The status word has this layout: bit 0 empty, bit 1 full, bit 2 overflow, bit 3 underflow, bit 4 set in `RD_WAIT_HI`, bits 7:5 zero, bits 15:8 the entry count.
- R11: The queue-clear command empties the queue, clears both sticky flags and forces `RD_WAIT_LO`. A push in the same cycle is dropped. Both counters are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Accepted trigger, one count per high cycle |
| ecr_i | input | 1 | Event-counter-reset pulse |
| evt_clr_i | input | 1 | Command: event number to 0xFFFFFF |
| epoch_clr_i | input | 1 | Command: epoch to 0 |
| fifo_clr_i | input | 1 | Command: empty the queue and clear the flags |
| rd_lo_i | input | 1 | Read strobe for the low halfword |
| rd_hi_i | input | 1 | Read strobe for the high halfword (low strobe wins if both are set) |
| cur_id_o | output | 32 | Current {epoch, event number} |
| led_o | output | 4 | Event bits 3:0 for the indicator |
| rd_data_o | output | 16 | Registered read data |
| status_o | output | 16 | Queue status word |

## Verification
Every result is due exactly one clock edge after its stimulus:
- the counters and the identifier,
- the queue count and flags,
- the registered read data.

The status word and the indicator are combinational from those registers. The bench drives each stimulus just after a falling edge and holds it through one rising edge. It samples at the next falling edge, so each check sees that single edge's effect.

Long stimuli are held as levels. A burst of 65,537 triggers drives the event number across bit 16. A train of 255 resets drives the epoch through its wrap. Each is checked once at its end.

// File: rtl/evq_pkg.sv
package evq_pkg;
    localparam int EVT_W  = 24;
    localparam int EPO_W  = 8;
    localparam int ID_W   = EVT_W + EPO_W;
    localparam int HALF_W = ID_W / 2;
    localparam int HI_EVT = HALF_W - EPO_W;

    typedef enum logic {
        RD_WAIT_LO = 1'b0,
        RD_WAIT_HI = 1'b1
    } rd_state_t;
endpackage

// File: rtl/evq_counters.sv
module evq_counters
    import evq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic             ecr_i,
    input  logic             evt_clr_i,
    input  logic             epoch_clr_i,
    output logic [ID_W-1:0]  cur_id_o,
    output logic             push_o,
    output logic [ID_W-1:0]  push_id_o
);
    localparam logic [EVT_W-1:0] EVT_RESTART = '1;

    logic [EVT_W-1:0] evt_q, evt_d, evt_inc;
    logic [EPO_W-1:0] epo_q, epo_d;
    logic             evt_restart;

    always_comb begin
        evt_restart = ecr_i | evt_clr_i;
        evt_inc     = evt_q + 1'b1;
        push_o      = trig_i & ~evt_restart;
        push_id_o   = {epo_q, evt_inc};

        evt_d = evt_q;
        if (evt_restart) begin
            evt_d = EVT_RESTART;
        end else if (trig_i) begin
            evt_d = evt_inc;
        end

        epo_d = epo_q;
        if (epoch_clr_i) begin
            epo_d = '0;
        end else if (ecr_i) begin
            epo_d = epo_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= EVT_RESTART;
            epo_q <= '0;
        end else begin
            evt_q <= evt_d;
            epo_q <= epo_d;
        end
    end

    assign cur_id_o = {epo_q, evt_q};
endmodule

// File: rtl/evq_fifo.sv
module evq_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             push_i,
    input  logic [W-1:0]     din_i,
    input  logic             pop_i,
    output logic [W-1:0]     head_o,
    output logic [CNT_W-1:0] count_o,
    output logic             empty_o,
    output logic             full_o,
    output logic             drop_o
);
    localparam bit                IS_POW2 = (DEPTH & (DEPTH - 1)) == 0;
    localparam logic [PTR_W-1:0]  LAST    = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0]  FULL_N  = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
    logic [CNT_W-1:0] count_q;
    logic             do_push, do_pop;

    generate
        if (IS_POW2) begin : g_wrap_free
            assign wr_nxt = wr_ptr + 1'b1;
            assign rd_nxt = rd_ptr + 1'b1;
        end else begin : g_wrap_cmp
            assign wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            assign rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    always_comb begin
        empty_o = (count_q == '0);
        full_o  = (count_q == FULL_N);
        do_push = push_i & ~full_o & ~clr_i;
        do_pop  = pop_i & ~empty_o & ~clr_i;
        drop_o  = push_i & full_o & ~clr_i;
        head_o  = mem[rd_ptr];
        count_o = count_q;
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_nxt;
            if (do_pop)  rd_ptr <= rd_nxt;
            case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end
endmodule

// File: rtl/evq_reader.sv
module evq_reader
    import evq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              rd_lo_i,
    input  logic              rd_hi_i,
    input  logic              empty_i,
    input  logic [ID_W-1:0]   head_i,
    output logic              pop_o,
    output logic              underflow_o,
    output logic [HALF_W-1:0] rd_data_o,
    output rd_state_t         state_o
);
    rd_state_t   state_q, state_d;
    logic        hi_sel;

    assign hi_sel = rd_hi_i & ~rd_lo_i;

    always_comb begin
        state_d = state_q;
        pop_o   = 1'b0;
        unique case (state_q)
            RD_WAIT_LO: begin
                if (rd_lo_i && !empty_i) state_d = RD_WAIT_HI;
            end
            RD_WAIT_HI: begin
                if (hi_sel) begin
                    state_d = RD_WAIT_LO;
                    pop_o   = ~empty_i;
                end
            end
            default: state_d = RD_WAIT_LO;
        endcase
        if (clr_i) state_d = RD_WAIT_LO;
        underflow_o = (rd_lo_i | rd_hi_i) & empty_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RD_WAIT_LO;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o <= '0;
        end else if (rd_lo_i) begin
            rd_data_o <= empty_i ? '0 : head_i[HALF_W-1:0];
        end else if (rd_hi_i) begin
            rd_data_o <= empty_i ? '0 : head_i[ID_W-1:HALF_W];
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/evq_top.sv
module evq_top
    import evq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trig_i,
    input  logic        ecr_i,
    input  logic        evt_clr_i,
    input  logic        epoch_clr_i,
    input  logic        fifo_clr_i,
    input  logic        rd_lo_i,
    input  logic        rd_hi_i,
    output logic [31:0] cur_id_o,
    output logic [3:0]  led_o,
    output logic [15:0] rd_data_o,
    output logic [15:0] status_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ID_W-1:0]  push_id, head;
    logic             push, pop, empty, full, drop, udf_evt;
    logic             ovf_q, udf_q;
    logic [CNT_W-1:0] count;
    rd_state_t        rd_state;

    evq_counters u_cnt (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .ecr_i(ecr_i),
        .evt_clr_i(evt_clr_i), .epoch_clr_i(epoch_clr_i),
        .cur_id_o(cur_id_o), .push_o(push), .push_id_o(push_id)
    );

    evq_fifo #(.DEPTH(DEPTH), .W(ID_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr_i(fifo_clr_i), .push_i(push),
        .din_i(push_id), .pop_i(pop), .head_o(head), .count_o(count),
        .empty_o(empty), .full_o(full), .drop_o(drop)
    );

    evq_reader u_rd (
        .clk(clk), .rst_n(rst_n), .clr_i(fifo_clr_i), .rd_lo_i(rd_lo_i),
        .rd_hi_i(rd_hi_i), .empty_i(empty), .head_i(head), .pop_o(pop),
        .underflow_o(udf_evt), .rd_data_o(rd_data_o), .state_o(rd_state)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || fifo_clr_i) begin
            ovf_q <= 1'b0;
            udf_q <= 1'b0;
        end else begin
            ovf_q <= ovf_q | drop;
            udf_q <= udf_q | udf_evt;
        end
    end

    always_comb begin
        status_o       = '0;
        status_o[0]    = empty;
        status_o[1]    = full;
        status_o[2]    = ovf_q;
        status_o[3]    = udf_q;
        status_o[4]    = (rd_state == RD_WAIT_HI);
        status_o[15:8] = 8'(count);
        led_o          = cur_id_o[3:0];
    end
endmodule

// File: rtl/evq_checker.sv
module evq_checker #(
    parameter int DEPTH = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        trig_i,
    input logic        ecr_i,
    input logic        evt_clr_i,
    input logic        epoch_clr_i,
    input logic        fifo_clr_i,
    input logic        rd_lo_i,
    input logic        rd_hi_i,
    input logic [31:0] cur_id_o,
    input logic [15:0] rd_data_o,
    input logic [15:0] status_o
);
    // R10
    empty_full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_o[0] && status_o[1]) && (32'(status_o[15:8]) <= DEPTH) && (status_o[7:5] == 3'b000));

    // R2
    evt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i && !ecr_i && !evt_clr_i |=> cur_id_o[23:0] == $past(cur_id_o[23:0]) + 24'd1);

    // R3
    ecr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ecr_i |=> cur_id_o[23:0] == 24'hFFFFFF);

    // R4
    epoch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        epoch_clr_i |=> cur_id_o[31:24] == 8'h00);

    // R6
    lo_enters_wait_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo_i && !status_o[0] && !fifo_clr_i |=> status_o[4]);

    // R8
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo_i || rd_hi_i) && status_o[0] && !fifo_clr_i |=> rd_data_o == 16'h0000 && status_o[3]);

    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[1] && trig_i && !ecr_i && !evt_clr_i && !fifo_clr_i |=> status_o[2]);

    // R11
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[2] && !fifo_clr_i |=> status_o[2]);

    // R11
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr_i |=> status_o[0] && !status_o[2] && !status_o[3] && !status_o[4]);
endmodule

bind evq_top evq_checker #(.DEPTH(DEPTH)) u_evq_checker (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .ecr_i(ecr_i),
    .evt_clr_i(evt_clr_i), .epoch_clr_i(epoch_clr_i), .fifo_clr_i(fifo_clr_i),
    .rd_lo_i(rd_lo_i), .rd_hi_i(rd_hi_i), .cur_id_o(cur_id_o),
    .rd_data_o(rd_data_o), .status_o(status_o)
);

// File: tb/evq_top_bench.sv
module evq_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_i = 0, ecr_i = 0, evt_clr_i = 0, epoch_clr_i = 0;
    logic        fifo_clr_i = 0, rd_lo_i = 0, rd_hi_i = 0;
    logic [31:0] cur_id_o;
    logic [3:0]  led_o;
    logic [15:0] rd_data_o, status_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    evq_top u_evq_top (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .ecr_i(ecr_i),
        .evt_clr_i(evt_clr_i), .epoch_clr_i(epoch_clr_i), .fifo_clr_i(fifo_clr_i),
        .rd_lo_i(rd_lo_i), .rd_hi_i(rd_hi_i), .cur_id_o(cur_id_o), .led_o(led_o),
        .rd_data_o(rd_data_o), .status_o(status_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // one-cycle stimulus: applied after a falling edge, removed after the next one
    task automatic drive(input logic t, e, ce, cp, cf, rl, rh);
        trig_i = t; ecr_i = e; evt_clr_i = ce; epoch_clr_i = cp;
        fifo_clr_i = cf; rd_lo_i = rl; rd_hi_i = rh;
        @(negedge clk);
        trig_i = 0; ecr_i = 0; evt_clr_i = 0; epoch_clr_i = 0;
        fifo_clr_i = 0; rd_lo_i = 0; rd_hi_i = 0;
    endtask

    task automatic t_reset();
        check("R1 id", cur_id_o, 32'h00FFFFFF);
        check("R1 status", 32'(status_o), 32'h0001);
        check("R1 rd_data", 32'(rd_data_o), 32'h0);
        check("R1 R5 led", 32'(led_o), 32'hF);
    endtask

    task automatic t_ecr();
        drive(0, 1, 0, 0, 0, 0, 0);
        check("R3 ecr id", cur_id_o, 32'h01FFFFFF);
        check("R3 ecr no push", 32'(status_o), 32'h0001);
    endtask

    task automatic t_trig();
        for (int k = 0; k < 3; k++) begin
            drive(1, 0, 0, 0, 0, 0, 0);
            check("R2 id", cur_id_o, 32'h01000000 + 32'(k));
        end
        check("R2 R10 count", 32'(status_o), 32'h0300);
        check("R5 led", 32'(led_o), 32'h2);
    endtask

    task automatic t_read();
        drive(0, 0, 0, 0, 0, 1, 0);
        check("R6 lo data", 32'(rd_data_o), 32'h0000);
        check("R6 R10 wait_hi", 32'(status_o), 32'h0310);
        drive(0, 0, 0, 0, 0, 0, 1);
        check("R7 hi data", 32'(rd_data_o), 32'h0100);
        check("R7 pop", 32'(status_o), 32'h0200);
    endtask

    task automatic t_hi_first();
        drive(0, 0, 0, 0, 0, 0, 1);
        check("R7 hi in wait_lo data", 32'(rd_data_o), 32'h0100);
        check("R7 hi in wait_lo no pop", 32'(status_o), 32'h0200);
        for (int k = 1; k < 3; k++) begin
            drive(0, 0, 0, 0, 0, 1, 0);
            check("R6 lo data", 32'(rd_data_o), 32'(k));
            drive(0, 0, 0, 0, 0, 0, 1);
            check("R7 hi data", 32'(rd_data_o), 32'h0100);
        end
        check("R7 drained", 32'(status_o), 32'h0001);
    endtask

    task automatic t_underflow();
        drive(0, 0, 0, 0, 0, 1, 0);
        check("R8 empty lo data", 32'(rd_data_o), 32'h0);
        check("R8 udf flag", 32'(status_o), 32'h0009);
        drive(0, 0, 0, 0, 0, 0, 1);
        check("R8 empty hi data", 32'(rd_data_o), 32'h0);
    endtask

    task automatic t_clear();
        drive(0, 0, 0, 0, 1, 0, 0);
        check("R11 flags cleared", 32'(status_o), 32'h0001);
        check("R11 counters kept", cur_id_o, 32'h01000002);
    endtask

    task automatic t_coincide();
        drive(1, 1, 0, 0, 0, 0, 0);
        check("R3 trig+ecr id", cur_id_o, 32'h02FFFFFF);
        check("R3 trig+ecr no push", 32'(status_o), 32'h0001);
    endtask

    task automatic t_cmds();
        drive(1, 0, 0, 0, 0, 0, 0);
        check("R2 after restart", cur_id_o, 32'h02000000);
        drive(0, 0, 1, 0, 0, 0, 0);
        check("R4 event clear", cur_id_o, 32'h02FFFFFF);
        drive(0, 0, 0, 1, 0, 0, 0);
        check("R4 epoch clear", cur_id_o, 32'h00FFFFFF);
        drive(0, 1, 0, 1, 0, 0, 0);
        check("R4 epoch clear wins", cur_id_o, 32'h00FFFFFF);
        drive(0, 1, 0, 0, 0, 0, 0);
        check("R3 epoch step", cur_id_o, 32'h01FFFFFF);
        check("R4 queue untouched", 32'(status_o), 32'h0100);
    endtask

    task automatic t_overflow();
        drive(0, 0, 0, 0, 1, 0, 0);
        trig_i = 1;
        repeat (32'h10001) @(negedge clk);
        trig_i = 0;
        check("R2 burst id", cur_id_o, 32'h01010000);
        check("R9 full+ovf", 32'(status_o), 32'h0806);
        drive(0, 0, 0, 0, 0, 1, 0);
        check("R9 oldest kept", 32'(rd_data_o), 32'h0000);
        drive(0, 0, 0, 0, 0, 0, 1);
        check("R9 hi", 32'(rd_data_o), 32'h0100);
        check("R9 ovf sticky", 32'(status_o), 32'h0704);
        drive(0, 0, 0, 0, 1, 0, 0);
        check("R11 clear", 32'(status_o), 32'h0001);
        drive(1, 0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 1, 0);
        check("R6 lo field", 32'(rd_data_o), 32'h0001);
        drive(0, 0, 0, 0, 0, 0, 1);
        check("R7 hi field", 32'(rd_data_o), 32'h0101);
    endtask

    task automatic t_epoch_wrap();
        ecr_i = 1;
        repeat (255) @(negedge clk);
        ecr_i = 0;
        check("R3 epoch wrap", cur_id_o, 32'h00FFFFFF);
    endtask

    task automatic t_clear_mid();
        drive(1, 0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 1, 0);
        check("R6 wait_hi", 32'(status_o), 32'h0110);
        drive(1, 0, 0, 0, 1, 0, 0);
        check("R11 flush state", 32'(status_o), 32'h0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_ecr();
        t_trig();
        t_read();
        t_hi_first();
        t_underflow();
        t_clear();
        t_coincide();
        t_cmds();
        t_overflow();
        t_epoch_wrap();
        t_clear_mid();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule